// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a 16-bit parallel NOR flash and turns three high-level requests into the command-register write cycles and status-read polling the device expects. A client presents one request at a time: prepare a block (init), program one word, or erase one block. The sequencer issues the bus cycles, polls the status word until the device reports ready, and leaves the device in read-array mode before it acknowledges.

A word program first reads the current content. The request is refused when it would need any bit to go from 0 to 1, because the device cannot do that without an erase. A long erase can be paused when an interrupt-request input is high. The sequencer suspends the erase, reports the paused state on a flag, and restarts the erase when the client pulses a resume input. A suspend that finds the erase already finished completes the request normally.

The client holds `req_valid` until `req_ack` and drops it in the acknowledge cycle. The flash data bus is split into an output, an input and an output-enable.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, all three strobes (`fl_ce_n`, `fl_we_n`, `fl_oe_n`) are high, `fl_dq_oe`, `req_ack` and `erase_suspended` are low.
- R2: Each bus write drives address and data one cycle before the strobe. It then holds `fl_ce_n`/`fl_we_n` low for exactly WR_PULSE cycles, with address and data stable throughout, and keeps the data driven one cycle after. `fl_we_n` and `fl_oe_n` are never low together.
- R3: A program request (`req_op`=1) reads the target word, then writes 0x60, 0xD0, 0x50, 0x40 and the data word to the target address. It reads status until bit 7 (ready) is 1, then writes 0xFF and acknowledges with `req_err`=0.
- R4: A program request whose data has a 1 where the current word has a 0, i.e. (~current & data) != 0, makes no write cycle and is acknowledged with `req_err`=1.
- R5: An erase request (`req_op`=2) writes 0x60, 0xD0, 0x50, 0x20, 0xD0, 0x70 to the block address. It polls status until bit 7 is 1, then writes 0xFF and acknowledges.
- R6: When a status read during an erase shows bit 7 = 0 while `irq_req` is high, the sequencer writes 0xB0 then 0x70 and polls status until bit 7 is 1.
- R7: If that post-suspend status has bit 6 (suspended) = 0, the sequencer writes 0xFF and acknowledges without raising `erase_suspended`.
- R8: If bit 6 = 1, it writes 0xFF and raises `erase_suspended`, with no bus cycle and no acknowledge until `resume_req`. On resume it writes 0xD0 and then 0x70 and goes back to erase polling.
- R9: An init request (`req_op`=0) writes 0x50, 0xFF, 0x60, 0xD0 and polls status until bit 7 is 1. It then writes 0x70 and reads status once. If bit 6 is 1, it writes 0xD0 and polls until bit 7 is 1. It finishes with 0xFF and acknowledges.
- R10: `irq_req` has no effect during program and init requests: no 0xB0 is written.
- R11: `req_ack` is a single-cycle pulse and `req_err` is high only with it. Request code 3 is acknowledged with `req_err`=1 and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (held until acknowledge) |
| req_op | input | 2 | 0 init, 1 program, 2 erase, 3 invalid |
| req_addr | input | ADDR_W | Word address (block base for init and erase) |
| req_data | input | 16 | Word to program |
| req_ack | output | 1 | Request finished (one-cycle pulse) |
| req_err | output | 1 | Request refused (valid with `req_ack`) |
| irq_req | input | 1 | Interrupt pending: pause a busy erase |
| resume_req | input | 1 | Resume a suspended erase |
| erase_suspended | output | 1 | Erase paused, waiting for resume |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash word address |
| fl_dq_out | output | 16 | Write data to flash |
| fl_dq_oe | output | 1 | Drive `fl_dq_out` onto the data bus |
| fl_dq_in | input | 16 | Read data from flash |

## Verification
The hardest situations to reach are the two suspend outcomes and the init pass that finds a previously suspended erase. Each depends on what the device reports at a precise point in a long command sequence. The bench contains a behavioural flash that decodes the command writes, counts down a busy time on status reads, and can be told to finish the erase the moment a suspend arrives. It can also start with a suspended erase already pending. Holding `irq_req` high from the start of an erase makes the first busy status read take the suspend path. The bench then watches for the suspended flag, checks that the bus stays quiet, and resumes.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int DATA_W   = 16;
    localparam int RDY_BIT  = 7;
    localparam int SUSP_BIT = 6;

    localparam logic [DATA_W-1:0] CMD_READ_ARRAY = 16'h00FF;
    localparam logic [DATA_W-1:0] CMD_CLR_STAT   = 16'h0050;
    localparam logic [DATA_W-1:0] CMD_CFG_SETUP  = 16'h0060;
    localparam logic [DATA_W-1:0] CMD_CONFIRM    = 16'h00D0;
    localparam logic [DATA_W-1:0] CMD_PROG_SETUP = 16'h0040;
    localparam logic [DATA_W-1:0] CMD_ERASE_SET  = 16'h0020;
    localparam logic [DATA_W-1:0] CMD_RD_STAT    = 16'h0070;
    localparam logic [DATA_W-1:0] CMD_SUSPEND    = 16'h00B0;

    typedef enum logic [1:0] {
        OP_INIT  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    // Fixed write bursts the sequencer can issue
    typedef enum logic [2:0] {
        SQ_PROG_PRE, SQ_ERASE_PRE, SQ_INIT_PRE, SQ_SUSPEND,
        SQ_RESUME,   SQ_STATUS,    SQ_INIT_RES, SQ_EXIT
    } seq_e;

    // What a status poll is waiting for
    typedef enum logic [2:0] {
        PK_PROG, PK_ERASE, PK_SUSP, PK_INIT1, PK_INIT2
    } poll_e;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              last;
        logic              is_data;
    } step_t;

    function automatic logic [2:0] seq_len(input seq_e s);
        case (s)
            SQ_PROG_PRE:  return 3'd5;
            SQ_ERASE_PRE: return 3'd6;
            SQ_INIT_PRE:  return 3'd4;
            SQ_SUSPEND:   return 3'd2;
            SQ_RESUME:    return 3'd2;
            default:      return 3'd1;
        endcase
    endfunction

    function automatic step_t seq_step(input seq_e s, input logic [2:0] i);
        step_t r;
        r.word    = CMD_READ_ARRAY;
        r.is_data = 1'b0;
        r.last    = (i == seq_len(s) - 3'd1);
        case (s)
            SQ_PROG_PRE: begin
                case (i)
                    3'd0:    r.word = CMD_CFG_SETUP;
                    3'd1:    r.word = CMD_CONFIRM;
                    3'd2:    r.word = CMD_CLR_STAT;
                    3'd3:    r.word = CMD_PROG_SETUP;
                    default: r.is_data = 1'b1;
                endcase
            end
            SQ_ERASE_PRE: begin
                case (i)
                    3'd0:    r.word = CMD_CFG_SETUP;
                    3'd1:    r.word = CMD_CONFIRM;
                    3'd2:    r.word = CMD_CLR_STAT;
                    3'd3:    r.word = CMD_ERASE_SET;
                    3'd4:    r.word = CMD_CONFIRM;
                    default: r.word = CMD_RD_STAT;
                endcase
            end
            SQ_INIT_PRE: begin
                case (i)
                    3'd0:    r.word = CMD_CLR_STAT;
                    3'd1:    r.word = CMD_READ_ARRAY;
                    3'd2:    r.word = CMD_CFG_SETUP;
                    default: r.word = CMD_CONFIRM;
                endcase
            end
            SQ_SUSPEND: r.word = (i == 3'd0) ? CMD_SUSPEND : CMD_RD_STAT;
            SQ_RESUME:  r.word = (i == 3'd0) ? CMD_CONFIRM : CMD_RD_STAT;
            SQ_STATUS:  r.word = CMD_RD_STAT;
            SQ_INIT_RES: r.word = CMD_CONFIRM;
            default:    r.word = CMD_READ_ARRAY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle
    import nfc_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int WR_PULSE = 2,
    parameter int RD_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_data,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int MAX_P = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
    localparam int CNT_W = $clog2(MAX_P + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_PULSE - 1);

    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bst_e;

    bst_e              st;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= B_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                B_IDLE: begin
                    if (go) begin
                        wr_q   <= go_wr;
                        addr_q <= go_addr;
                        data_q <= go_data;
                        st     <= B_SETUP;
                    end
                end
                B_SETUP: begin
                    cnt <= wr_q ? WR_LOAD : RD_LOAD;
                    st  <= B_STROBE;
                end
                B_STROBE: begin
                    if (cnt == '0) begin
                        if (!wr_q) rdata_q <= dq_in;
                        st <= B_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    assign ce_n   = (st != B_STROBE);
    assign we_n   = !((st == B_STROBE) && wr_q);
    assign oe_n   = !((st == B_STROBE) && !wr_q);
    assign dq_oe  = wr_q && (st != B_IDLE);
    assign addr   = addr_q;
    assign dq_out = data_q;
    assign done   = (st == B_HOLD);
    assign rdata  = rdata_q;

endmodule

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ack,
    output logic              req_err,
    input  logic              irq_req,
    input  logic              resume_req,
    output logic              suspended,
    output logic              bus_go,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata
);

    typedef enum logic [2:0] {
        S_IDLE, S_RD_OLD, S_WSEQ, S_POLL, S_RD_STAT, S_SUSP_WAIT, S_DONE
    } st_e;

    st_e               st;
    seq_e              seq_q;
    logic [2:0]        idx_q;
    poll_e             pk_q;
    logic              pend_q;
    logic              to_susp_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    step_t             step;
    logic              rdy;

    assign step = seq_step(seq_q, idx_q);
    assign rdy  = bus_rdata[RDY_BIT];

    assign bus_go    = !pend_q && ((st == S_RD_OLD) || (st == S_WSEQ) ||
                                   (st == S_POLL)   || (st == S_RD_STAT));
    assign bus_wr    = (st == S_WSEQ);
    assign bus_addr  = addr_q;
    assign bus_wdata = step.is_data ? data_q : step.word;

    assign req_ack   = (st == S_DONE);
    assign req_err   = (st == S_DONE) && err_q;
    assign suspended = (st == S_SUSP_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            seq_q     <= SQ_EXIT;
            idx_q     <= '0;
            pk_q      <= PK_PROG;
            pend_q    <= 1'b0;
            to_susp_q <= 1'b0;
            err_q     <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            if (bus_go)   pend_q <= 1'b1;
            if (bus_done) pend_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q    <= req_addr;
                        data_q    <= req_data;
                        err_q     <= 1'b0;
                        to_susp_q <= 1'b0;
                        idx_q     <= '0;
                        case (op_e'(req_op))
                            OP_PROG:  st <= S_RD_OLD;
                            OP_ERASE: begin st <= S_WSEQ; seq_q <= SQ_ERASE_PRE; end
                            OP_INIT:  begin st <= S_WSEQ; seq_q <= SQ_INIT_PRE;  end
                            default:  begin st <= S_DONE; err_q <= 1'b1;        end
                        endcase
                    end
                end
                S_RD_OLD: begin
                    if (bus_done) begin
                        if ((~bus_rdata & data_q) != '0) begin
                            err_q <= 1'b1;
                            st    <= S_DONE;
                        end else begin
                            st    <= S_WSEQ;
                            seq_q <= SQ_PROG_PRE;
                            idx_q <= '0;
                        end
                    end
                end
                S_WSEQ: begin
                    if (bus_done) begin
                        if (!step.last) begin
                            idx_q <= idx_q + 3'd1;
                        end else begin
                            idx_q <= '0;
                            st    <= S_POLL;
                            case (seq_q)
                                SQ_PROG_PRE:  pk_q <= PK_PROG;
                                SQ_ERASE_PRE: pk_q <= PK_ERASE;
                                SQ_INIT_PRE:  pk_q <= PK_INIT1;
                                SQ_SUSPEND:   pk_q <= PK_SUSP;
                                SQ_RESUME:    pk_q <= PK_ERASE;
                                SQ_INIT_RES:  pk_q <= PK_INIT2;
                                SQ_STATUS:    st   <= S_RD_STAT;
                                default:      st   <= to_susp_q ? S_SUSP_WAIT : S_DONE;
                            endcase
                        end
                    end
                end
                S_POLL: begin
                    if (bus_done) begin
                        if (!rdy) begin
                            if ((pk_q == PK_ERASE) && irq_req) begin
                                st    <= S_WSEQ;
                                seq_q <= SQ_SUSPEND;
                                idx_q <= '0;
                            end
                        end else begin
                            st    <= S_WSEQ;
                            idx_q <= '0;
                            case (pk_q)
                                PK_INIT1: seq_q <= SQ_STATUS;
                                PK_SUSP: begin
                                    seq_q     <= SQ_EXIT;
                                    to_susp_q <= bus_rdata[SUSP_BIT];
                                end
                                default:  seq_q <= SQ_EXIT;
                            endcase
                        end
                    end
                end
                S_RD_STAT: begin
                    if (bus_done) begin
                        st    <= S_WSEQ;
                        idx_q <= '0;
                        seq_q <= bus_rdata[SUSP_BIT] ? SQ_INIT_RES : SQ_EXIT;
                    end
                end
                S_SUSP_WAIT: begin
                    if (resume_req) begin
                        to_susp_q <= 1'b0;
                        st        <= S_WSEQ;
                        seq_q     <= SQ_RESUME;
                        idx_q     <= '0;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nfc_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int WR_PULSE = 2,
    parameter int RD_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    output logic              req_ack,
    output logic              req_err,
    input  logic              irq_req,
    input  logic              resume_req,
    output logic              erase_suspended,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [15:0]       fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [15:0]       fl_dq_in
);

    logic              bus_go;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_done;
    logic [DATA_W-1:0] bus_rdata;

    nfc_seq_fsm #(.ADDR_W(ADDR_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_ack    (req_ack),
        .req_err    (req_err),
        .irq_req    (irq_req),
        .resume_req (resume_req),
        .suspended  (erase_suspended),
        .bus_go     (bus_go),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_done   (bus_done),
        .bus_rdata  (bus_rdata)
    );

    nfc_bus_cycle #(
        .ADDR_W   (ADDR_W),
        .WR_PULSE (WR_PULSE),
        .RD_PULSE (RD_PULSE)
    ) bus_i (
        .clk     (clk),
        .rst     (rst),
        .go      (bus_go),
        .go_wr   (bus_wr),
        .go_addr (bus_addr),
        .go_data (bus_wdata),
        .done    (bus_done),
        .rdata   (bus_rdata),
        .ce_n    (fl_ce_n),
        .we_n    (fl_we_n),
        .oe_n    (fl_oe_n),
        .addr    (fl_addr),
        .dq_out  (fl_dq_out),
        .dq_oe   (fl_dq_oe),
        .dq_in   (fl_dq_in)
    );

endmodule

// File: rtl/nfc_chk.sv
module nfc_chk #(
    parameter int ADDR_W   = 20,
    parameter int WR_PULSE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       dq_out,
    input logic              req_ack,
    input logic              req_err,
    input logic              suspended
);

    logic [7:0] wlow;

    always_ff @(posedge clk) begin
        if (rst)       wlow <= '0;
        else if (!we_n) wlow <= wlow + 8'd1;
        else           wlow <= '0;
    end

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n)); // R2
    AST_DATA_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe); // R2
    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> $past(dq_oe)); // R2
    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> dq_oe); // R2
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(dq_out))); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (wlow == 8'(WR_PULSE))); // R2
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack); // R11
    AST_ERR_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_ack); // R11
    AST_QUIET_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (ce_n && !dq_oe)); // R8
    AST_NO_ACK_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
        suspended |-> !req_ack); // R8

endmodule

bind nor_cmd_seq nfc_chk #(.ADDR_W(ADDR_W), .WR_PULSE(WR_PULSE)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (fl_ce_n),
    .we_n      (fl_we_n),
    .oe_n      (fl_oe_n),
    .dq_oe     (fl_dq_oe),
    .addr      (fl_addr),
    .dq_out    (fl_dq_out),
    .req_ack   (req_ack),
    .req_err   (req_err),
    .suspended (erase_suspended)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;

    localparam int AW = 20;
    localparam int WP = 2;
    localparam int PROG_BUSY = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          req_ack, req_err;
    logic          irq_req = 1'b0;
    logic          resume_req = 1'b0;
    logic          erase_suspended;
    logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [15:0]   fl_dq_out, fl_dq_in;

    always #4 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .WR_PULSE(WP), .RD_PULSE(2)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ack(req_ack),
        .req_err(req_err), .irq_req(irq_req), .resume_req(resume_req),
        .erase_suspended(erase_suspended), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    // ---------------- behavioural flash ----------------
    logic [15:0] m_mem [16];
    logic        m_stat = 1'b0;
    logic        m_expect_data = 1'b0;
    logic        m_erase_setup = 1'b0;
    logic        m_susp = 1'b0;
    logic        m_fin_on_susp = 1'b0;
    logic [15:0] m_last = 16'h0;
    int          m_busy = 0;
    int          m_erase_busy = 3;
    logic        prev_we_n = 1'b1, prev_oe_n = 1'b1;
    int          wcnt = 0;
    int          width_viol = 0;
    logic [15:0] log_d [64];
    logic [AW-1:0] log_a [64];
    int          log_n = 0;
    logic        seen_susp = 1'b0;

    assign fl_dq_in = m_stat ? {8'h00, ((m_busy == 0) || m_susp), m_susp, 6'b0}
                             : m_mem[fl_addr[3:0]];

    always @(negedge clk) begin
        if (erase_suspended) seen_susp = 1'b1;
        if (!fl_we_n) wcnt = wcnt + 1;
        if (fl_we_n && !prev_we_n) begin
            if (wcnt != WP) width_viol = width_viol + 1;
            wcnt = 0;
        end
        if (!fl_we_n && prev_we_n) begin
            if (log_n < 64) begin
                log_d[log_n] = fl_dq_out;
                log_a[log_n] = fl_addr;
                log_n = log_n + 1;
            end
            if (m_expect_data) begin
                m_mem[fl_addr[3:0]] = m_mem[fl_addr[3:0]] & fl_dq_out;
                m_busy = PROG_BUSY;
                m_expect_data = 1'b0;
                m_stat = 1'b1;
            end else begin
                m_stat = 1'b1;
                case (fl_dq_out)
                    16'h00FF: m_stat = 1'b0;
                    16'h0040: m_expect_data = 1'b1;
                    16'h0020: m_erase_setup = 1'b1;
                    16'h00D0: begin
                        if (m_erase_setup) begin
                            m_busy = m_erase_busy;
                            m_erase_setup = 1'b0;
                        end else if (m_last != 16'h0060 && m_susp) begin
                            m_susp = 1'b0;
                        end
                    end
                    16'h00B0: begin
                        if (m_busy > 0) begin
                            if (m_fin_on_susp) m_busy = 0;
                            else m_susp = 1'b1;
                        end
                    end
                    default: ;
                endcase
                m_last = fl_dq_out;
            end
        end
        if (fl_oe_n && !prev_oe_n) begin
            if (m_stat && m_busy > 0 && !m_susp) m_busy = m_busy - 1;
        end
        prev_we_n = fl_we_n;
        prev_oe_n = fl_oe_n;
    end

    // ---------------- expected write log ----------------
    logic [15:0] exp_d [32];
    int exp_n = 0;

    task automatic ex_clear();
        exp_n = 0;
    endtask

    task automatic ex(input logic [15:0] w);
        exp_d[exp_n] = w;
        exp_n = exp_n + 1;
    endtask

    task automatic chk_log(input string tag, input logic [AW-1:0] a);
        string why;
        bit ok;
        ok = (log_n == exp_n);
        why = $sformatf("log length %0d expected %0d", log_n, exp_n);
        if (ok) begin
            for (int i = 0; i < exp_n; i++) begin
                if (ok && (log_d[i] != exp_d[i] || log_a[i] != a)) begin
                    ok = 1'b0;
                    why = $sformatf("write %0d got %h@%h expected %h@%h",
                                    i, log_d[i], log_a[i], exp_d[i], a);
                end
            end
        end
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, why);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    // run a request; returns when acknowledged or suspended
    task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [15:0] d, output bit got_ack,
                           output bit got_err, output bit got_susp);
        got_ack = 0; got_err = 0; got_susp = 0;
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (req_ack) begin
                got_ack = 1; got_err = req_err; req_valid = 1'b0;
                break;
            end
            if (erase_suspended) begin
                got_susp = 1;
                break;
            end
        end
    endtask

    task automatic wait_ack(output bit got_ack, output bit got_err);
        got_ack = 0; got_err = 0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (req_ack) begin
                got_ack = 1; got_err = req_err; req_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic start_log();
        log_n = 0;
        seen_susp = 1'b0;
    endtask

    // {current word, requested word, expected refusal}
    localparam logic [32:0] PVEC [6] = '{
        {16'hFFFF, 16'h1234, 1'b0},
        {16'h00FF, 16'h00F0, 1'b0},
        {16'h00FF, 16'h01FF, 1'b1},
        {16'hA5A5, 16'hA5A5, 1'b0},
        {16'h0000, 16'h0001, 1'b1},
        {16'hF0F0, 16'h0000, 1'b0}
    };

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit a, e, s;
        logic [AW-1:0] ba;
        for (int i = 0; i < 16; i++) m_mem[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 idle outputs", {26'd0, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, req_ack, erase_suspended},
            {26'd0, 6'b111000});

        // R3 / R4: program vector table
        for (int v = 0; v < 6; v++) begin
            logic [15:0] o, nw;
            logic er;
            {o, nw, er} = PVEC[v];
            ba = 20'h0A000 | AW'(v);
            m_mem[v] = o;
            start_log();
            ex_clear();
            if (!er) begin
                ex(16'h60); ex(16'hD0); ex(16'h50); ex(16'h40); ex(nw); ex(16'hFF);
            end
            run_req(2'd1, ba, nw, a, e, s);
            chk(er ? "R4 refused program err" : "R3 program err", {30'd0, a, e}, {30'd0, 1'b1, er});
            chk_log(er ? "R4 no writes on refusal" : "R3 program sequence", ba);
            chk(er ? "R4 content unchanged" : "R3 content programmed",
                {16'd0, m_mem[v]}, {16'd0, er ? o : (o & nw)});
        end

        // R10: irq has no effect on a program
        m_mem[7] = 16'hFFFF;
        irq_req = 1'b1;
        start_log(); ex_clear();
        ex(16'h60); ex(16'hD0); ex(16'h50); ex(16'h40); ex(16'h00AA); ex(16'hFF);
        run_req(2'd1, 20'h0A007, 16'h00AA, a, e, s);
        chk_log("R10 program ignores irq", 20'h0A007);
        // R10: irq has no effect on init
        start_log(); ex_clear();
        ex(16'h50); ex(16'hFF); ex(16'h60); ex(16'hD0); ex(16'h70); ex(16'hFF);
        run_req(2'd0, 20'h10000, 16'h0, a, e, s);
        chk_log("R10 init ignores irq", 20'h10000);
        irq_req = 1'b0;

        // R5: plain erase
        m_erase_busy = 3;
        start_log(); ex_clear();
        ex(16'h60); ex(16'hD0); ex(16'h50); ex(16'h20); ex(16'hD0); ex(16'h70); ex(16'hFF);
        run_req(2'd2, 20'h20000, 16'h0, a, e, s);
        chk("R5 erase ack", {30'd0, a, e}, {30'd0, 2'b10});
        chk_log("R5 erase sequence", 20'h20000);

        // R6 / R7: suspend finds the erase already finished
        m_fin_on_susp = 1'b1;
        irq_req = 1'b1;
        start_log(); ex_clear();
        ex(16'h60); ex(16'hD0); ex(16'h50); ex(16'h20); ex(16'hD0); ex(16'h70);
        ex(16'hB0); ex(16'h70); ex(16'hFF);
        run_req(2'd2, 20'h30000, 16'h0, a, e, s);
        chk("R7 acked without suspend", {29'd0, a, e, seen_susp}, {29'd0, 3'b100});
        chk_log("R6 R7 suspend then finish", 20'h30000);
        m_fin_on_susp = 1'b0;

        // R6 / R8: real suspend, then resume
        start_log(); ex_clear();
        ex(16'h60); ex(16'hD0); ex(16'h50); ex(16'h20); ex(16'hD0); ex(16'h70);
        ex(16'hB0); ex(16'h70); ex(16'hFF);
        run_req(2'd2, 20'h40000, 16'h0, a, e, s);
        chk("R8 suspended flag", {30'd0, s, a}, {30'd0, 2'b10});
        chk_log("R6 R8 suspend sequence", 20'h40000);
        irq_req = 1'b0;
        begin
            int n0;
            bit acked;
            n0 = log_n;
            acked = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (req_ack) acked = 1;
            end
            chk("R8 bus quiet while suspended", {30'd0, acked, erase_suspended}, {30'd0, 2'b01});
            chk("R8 no writes while suspended", 32'(log_n), 32'(n0));
        end
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
        ex(16'hD0); ex(16'h70); ex(16'hFF);
        wait_ack(a, e);
        chk("R8 resumed erase acked", {30'd0, a, e}, {30'd0, 2'b10});
        chk_log("R8 resume sequence", 20'h40000);
        chk("R8 flash left not suspended", {31'd0, m_susp}, 32'd0);

        // R9: init with a suspended erase pending in the device
        m_susp = 1'b1;
        m_busy = 2;
        start_log(); ex_clear();
        ex(16'h50); ex(16'hFF); ex(16'h60); ex(16'hD0); ex(16'h70); ex(16'hD0); ex(16'hFF);
        run_req(2'd0, 20'h50000, 16'h0, a, e, s);
        chk("R9 init ack", {30'd0, a, e}, {30'd0, 2'b10});
        chk_log("R9 init resumes pending erase", 20'h50000);
        chk("R9 device resumed and idle", {31'd0, (m_susp || m_busy != 0)}, 32'd0);

        // R11: invalid request code
        start_log(); ex_clear();
        run_req(2'd3, 20'h60000, 16'h0, a, e, s);
        chk("R11 invalid code refused", {30'd0, a, e}, {30'd0, 2'b11});
        chk_log("R11 no bus cycle on invalid code", 20'h60000);
        @(negedge clk);
        chk("R11 ack is one cycle", {31'd0, req_ack}, 32'd0);

        // R2: strobe width over the whole run
        chk("R2 write strobe width", 32'(width_viol), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule